// File: doc/BRIEF.md
# 8-bit Arithmetic and Logic Unit with Flag Generation

This block is the purely combinational datapath heart of a small microcontroller core. It takes two 8-bit operands, the current six-bit status word and a 5-bit operation code. It returns the 8-bit result, a write-enable telling the register file whether the result should be stored, the merged status word, and a mask showing which status bits the operation touched.

Every operation carries its own set of affected flags. Status bits outside that set pass from `flags_i` to `flags_o` unchanged. The incoming carry feeds the carry-chained arithmetic and the rotates. The incoming zero flag makes the carry-chained subtract and compare usable across several bytes: zero can only stay set or be cleared, never set afresh. Compares go through the same subtractor, but the write-enable is dropped so the result is discarded.

Top module: `alu8_core`

## Requirements
- R1: Status bit positions are C=0, Z=1, N=2, V=3, S=4, H=5. Opcode 0 (add) and 1 (add with incoming carry) give the low 8 bits of the sum. C is the carry out of bit 7, H is the carry out of bit 3, V is signed overflow, N is bit 7 and Z is set when the result is zero. All six bits are updated.
- R2: Opcode 2 (subtract), 3 (subtract with incoming carry) and 6 (negate, 0 minus A) give the difference. C is the borrow out of bit 7, H is the borrow out of bit 3 and V is signed overflow. All six bits are updated.
- R3: Opcode 4 (compare) and 5 (compare with carry) set flags exactly as opcodes 2 and 3 do, but drive `res_we_o` low. Every other defined opcode drives it high.
- R4: For opcodes 3 and 5, the new Z is set only if the result is zero and the incoming Z was set.
- R5: Opcode 7 (AND), 8 (OR) and 9 (XOR) update only Z, N, V and S, with V cleared. C and H keep their incoming values.
- R6: Opcode 10 (one's complement) gives 0xFF minus A, sets C, clears V, updates Z, N and S, and keeps H.
- R7: Opcode 11 (increment) and 12 (decrement) update only Z, N, V and S. V is set for 0x7F to 0x80 and for 0x80 to 0x7F. C and H are kept.
- R8: Opcode 13 (shift left) inserts 0 at bit 0 and moves bit 7 into C, with H taken from operand bit 3. Opcode 14 (shift right) inserts 0 at bit 7 and moves bit 0 into C, leaving H kept. For both, V equals N xor C.
- R9: Opcode 15 (rotate left) loads the incoming C into bit 0 and bit 7 into C, with H taken from operand bit 3. Opcode 16 (rotate right) loads the incoming C into bit 7 and bit 0 into C, leaving H kept. For both, V equals N xor C.
- R10: Opcode 17 (arithmetic shift right) keeps bit 7, moves bit 0 into C, and sets V to N xor C.
- R11: Opcode 18 (nibble swap) exchanges bits 7..4 with bits 3..0 and updates no status bit.
- R12: `upd_o` marks the updated status bits. Each unmarked bit of `flags_o` equals the same bit of `flags_i`. Whenever N or V is updated, S is updated to N xor V.
- R13: Opcodes 19 to 31 are no-operations: the result equals A, `res_we_o` is low and `upd_o` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation code |
| a_i | input | 8 | First operand (destination value) |
| b_i | input | 8 | Second operand |
| flags_i | input | 6 | Incoming status word |
| res_o | output | 8 | Operation result |
| res_we_o | output | 1 | Result should be written back |
| flags_o | output | 6 | Status word after the operation |
| upd_o | output | 6 | Mask of status bits the operation affects |

## Verification
Every output is due in the same cycle as the stimulus, with no register in any path. The bench therefore drives a new operation on the falling clock edge and compares all four outputs one nanosecond later, well before the next rising edge. Directed vectors hit the overflow, borrow, sticky-zero and carry-rotation corners. These are followed by seeded random operations over all 32 codes, each checked against a bench model written in integer arithmetic.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int NFLAG = 6;
  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FN = 2;
  localparam int FV = 3;
  localparam int FS = 4;
  localparam int FH = 5;

  localparam logic [NFLAG-1:0] M_ALL   = 6'b111111;
  localparam logic [NFLAG-1:0] M_ZNVS  = 6'b011110;
  localparam logic [NFLAG-1:0] M_ZCNVS = 6'b011111;
  localparam logic [NFLAG-1:0] M_NONE  = 6'b000000;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBC  = 5'd3,
    OP_CMP  = 5'd4,
    OP_CPC  = 5'd5,
    OP_NEG  = 5'd6,
    OP_AND  = 5'd7,
    OP_OR   = 5'd8,
    OP_XOR  = 5'd9,
    OP_COM  = 5'd10,
    OP_INC  = 5'd11,
    OP_DEC  = 5'd12,
    OP_LSL  = 5'd13,
    OP_LSR  = 5'd14,
    OP_ROL  = 5'd15,
    OP_ROR  = 5'd16,
    OP_ASR  = 5'd17,
    OP_SWAP = 5'd18
  } alu_op_e;

  typedef enum logic [1:0] {
    GRP_ARITH = 2'd0,
    GRP_BITS  = 2'd1,
    GRP_SHIFT = 2'd2
  } grp_e;

  typedef enum logic [1:0] {
    YSEL_B   = 2'd0,
    YSEL_ONE = 2'd1,
    YSEL_A   = 2'd2
  } ysel_e;

  typedef struct packed {
    grp_e             grp;
    logic             sub;
    logic             xzero;
    ysel_e            ysel;
    logic             cuse;
    logic             zsticky;
    logic [NFLAG-1:0] upd;
    logic             we;
  } ctl_t;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         ci_i,
  input  logic         sub_i,
  output logic [W-1:0] r_o,
  output logic         c_o,
  output logic         h_o,
  output logic         v_o
);
  localparam int HW = W / 2;

  logic [W:0]  full;
  logic [HW:0] half;

  always_comb begin
    if (sub_i) begin
      full = {1'b0, x_i} - {1'b0, y_i} - {{W{1'b0}}, ci_i};
      half = {1'b0, x_i[HW-1:0]} - {1'b0, y_i[HW-1:0]} - {{HW{1'b0}}, ci_i};
    end else begin
      full = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, ci_i};
      half = {1'b0, x_i[HW-1:0]} + {1'b0, y_i[HW-1:0]} + {{HW{1'b0}}, ci_i};
    end
  end

  assign r_o = full[W-1:0];
  assign c_o = full[W];
  assign h_o = half[HW];

  always_comb begin
    if (sub_i)
      v_o = (x_i[W-1] != y_i[W-1]) && (full[W-1] != x_i[W-1]);
    else
      v_o = (x_i[W-1] == y_i[W-1]) && (full[W-1] != x_i[W-1]);
  end

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] r_o
);
  localparam int HW = W / 2;

  always_comb begin
    case (op_i)
      OP_AND:  r_o = a_i & b_i;
      OP_OR:   r_o = a_i | b_i;
      OP_XOR:  r_o = a_i ^ b_i;
      OP_COM:  r_o = ~a_i;
      OP_SWAP: r_o = {a_i[HW-1:0], a_i[W-1:HW]};
      default: r_o = a_i;
    endcase
  end

endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic         ci_i,
  output logic [W-1:0] r_o,
  output logic         c_o
);
  logic left;
  logic fill;

  always_comb begin
    left = (op_i == OP_LSL) || (op_i == OP_ROL);
    case (op_i)
      OP_ROL, OP_ROR: fill = ci_i;
      OP_ASR:         fill = a_i[W-1];
      default:        fill = 1'b0;
    endcase
    if (left) begin
      r_o = {a_i[W-2:0], fill};
      c_o = a_i[W-1];
    end else begin
      r_o = {fill, a_i[W-1:1]};
      c_o = a_i[0];
    end
  end

endmodule

// File: rtl/alu8_decode.sv
module alu8_decode
  import alu8_pkg::*;
(
  input  alu_op_e op_i,
  output ctl_t    ctl_o
);
  always_comb begin
    ctl_o         = '0;
    ctl_o.grp     = GRP_ARITH;
    ctl_o.ysel    = YSEL_B;
    ctl_o.we      = 1'b1;
    ctl_o.upd     = M_ALL;
    case (op_i)
      OP_ADD: ;
      OP_ADC: ctl_o.cuse = 1'b1;
      OP_SUB: ctl_o.sub  = 1'b1;
      OP_SBC: begin
        ctl_o.sub     = 1'b1;
        ctl_o.cuse    = 1'b1;
        ctl_o.zsticky = 1'b1;
      end
      OP_CMP: begin
        ctl_o.sub = 1'b1;
        ctl_o.we  = 1'b0;
      end
      OP_CPC: begin
        ctl_o.sub     = 1'b1;
        ctl_o.cuse    = 1'b1;
        ctl_o.zsticky = 1'b1;
        ctl_o.we      = 1'b0;
      end
      OP_NEG: begin
        ctl_o.sub   = 1'b1;
        ctl_o.xzero = 1'b1;
        ctl_o.ysel  = YSEL_A;
      end
      OP_INC: begin
        ctl_o.ysel = YSEL_ONE;
        ctl_o.upd  = M_ZNVS;
      end
      OP_DEC: begin
        ctl_o.sub  = 1'b1;
        ctl_o.ysel = YSEL_ONE;
        ctl_o.upd  = M_ZNVS;
      end
      OP_AND, OP_OR, OP_XOR: begin
        ctl_o.grp = GRP_BITS;
        ctl_o.upd = M_ZNVS;
      end
      OP_COM: begin
        ctl_o.grp = GRP_BITS;
        ctl_o.upd = M_ZCNVS;
      end
      OP_SWAP: begin
        ctl_o.grp = GRP_BITS;
        ctl_o.upd = M_NONE;
      end
      OP_LSL, OP_ROL: begin
        ctl_o.grp  = GRP_SHIFT;
        ctl_o.cuse = 1'b1;
        ctl_o.upd  = M_ALL;
      end
      OP_LSR, OP_ROR, OP_ASR: begin
        ctl_o.grp  = GRP_SHIFT;
        ctl_o.cuse = 1'b1;
        ctl_o.upd  = M_ZCNVS;
      end
      default: begin
        ctl_o.grp = GRP_BITS;
        ctl_o.upd = M_NONE;
        ctl_o.we  = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [4:0]       op_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic [NFLAG-1:0] flags_i,
  output logic [W-1:0]     res_o,
  output logic             res_we_o,
  output logic [NFLAG-1:0] flags_o,
  output logic [NFLAG-1:0] upd_o
);
  localparam int HW = W / 2;

  alu_op_e op;
  ctl_t    ctl;

  logic [W-1:0] ar_x, ar_y, ar_r, bit_r, sh_r;
  logic         ar_ci, ar_c, ar_h, ar_v, sh_c;
  logic         n_c, n_z, n_n, n_v, n_h;
  logic [NFLAG-1:0] n_flags;

  assign op = alu_op_e'(op_i);

  alu8_decode u_dec (
    .op_i  (op),
    .ctl_o (ctl)
  );

  always_comb begin
    ar_x = ctl.xzero ? '0 : a_i;
    case (ctl.ysel)
      YSEL_ONE: ar_y = W'(1);
      YSEL_A:   ar_y = a_i;
      default:  ar_y = b_i;
    endcase
    ar_ci = ctl.cuse & flags_i[FC];
  end

  alu8_addsub #(.W(W)) u_addsub (
    .x_i   (ar_x),
    .y_i   (ar_y),
    .ci_i  (ar_ci),
    .sub_i (ctl.sub),
    .r_o   (ar_r),
    .c_o   (ar_c),
    .h_o   (ar_h),
    .v_o   (ar_v)
  );

  alu8_bitops #(.W(W)) u_bits (
    .op_i (op),
    .a_i  (a_i),
    .b_i  (b_i),
    .r_o  (bit_r)
  );

  alu8_shifter #(.W(W)) u_shift (
    .op_i (op),
    .a_i  (a_i),
    .ci_i (ar_ci),
    .r_o  (sh_r),
    .c_o  (sh_c)
  );

  always_comb begin
    case (ctl.grp)
      GRP_ARITH: begin
        res_o = ar_r;
        n_c   = ar_c;
        n_h   = ar_h;
      end
      GRP_SHIFT: begin
        res_o = sh_r;
        n_c   = sh_c;
        n_h   = a_i[HW-1];
      end
      default: begin
        res_o = bit_r;
        n_c   = 1'b1;
        n_h   = 1'b0;
      end
    endcase
    n_n = res_o[W-1];
    case (ctl.grp)
      GRP_ARITH: n_v = ar_v;
      GRP_SHIFT: n_v = n_n ^ n_c;
      default:   n_v = 1'b0;
    endcase
    n_z = (res_o == '0) && (!ctl.zsticky || flags_i[FZ]);
    n_flags        = '0;
    n_flags[FC]    = n_c;
    n_flags[FZ]    = n_z;
    n_flags[FN]    = n_n;
    n_flags[FV]    = n_v;
    n_flags[FS]    = n_n ^ n_v;
    n_flags[FH]    = n_h;
  end

  assign upd_o    = ctl.upd;
  assign res_we_o = ctl.we;
  assign flags_o  = (flags_i & ~ctl.upd) | (n_flags & ctl.upd);

  // Checks on the merged outputs against the decode and the incoming status
  always_comb begin
    // R12: S follows N xor V when written
    p_s_follows_nv_r12: assert (!upd_o[FS] || (flags_o[FS] == (flags_o[FN] ^ flags_o[FV])))
      else $error("S flag inconsistent");
    // R12: untouched status bits pass through
    p_keep_unmasked_r12: assert (((flags_o ^ flags_i) & ~upd_o) == '0)
      else $error("unmasked flag changed");
    // R3: compares never request write-back
    p_cmp_no_write_r3: assert (!((op == OP_CMP) || (op == OP_CPC)) || !res_we_o)
      else $error("compare wrote result");
    // R4: chained Z can never become set
    p_sticky_z_r4: assert (!((op == OP_SBC) || (op == OP_CPC)) || flags_i[FZ] || !flags_o[FZ])
      else $error("chained zero set from clear");
    // R5: logic operations clear V
    p_logic_v_clear_r5: assert (!((op == OP_AND) || (op == OP_OR) || (op == OP_XOR)) || !flags_o[FV])
      else $error("logic op left V set");
    // R7: increment and decrement keep carry
    p_incdec_keep_c_r7: assert (!((op == OP_INC) || (op == OP_DEC)) || (flags_o[FC] == flags_i[FC]))
      else $error("inc/dec changed C");
    // R11: swap touches no flag
    p_swap_no_flags_r11: assert ((op != OP_SWAP) || (flags_o == flags_i))
      else $error("swap changed flags");
    // R1: non-chained Z reflects the result
    p_zero_flag_r1: assert (!upd_o[FZ] || ctl.zsticky || (flags_o[FZ] == (res_o == '0)))
      else $error("Z mismatch");
  end

endmodule

// File: tb/alu8_core_tb.sv
module alu8_core_tb;

  logic       clk;
  logic       rst_n;
  logic [4:0] op;
  logic [7:0] a, b;
  logic [5:0] fin;
  logic [7:0] res;
  logic       we;
  logic [5:0] fout, upd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  alu8_core u_dut (
    .op_i     (op),
    .a_i      (a),
    .b_i      (b),
    .flags_i  (fin),
    .res_o    (res),
    .res_we_o (we),
    .flags_o  (fout),
    .upd_o    (upd)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int sx(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // returns {we, upd[5:0], flags[5:0], res[7:0]}
  function automatic logic [20:0] model(input int o, input int x0, input int y0, input logic [5:0] f);
    int ci, cx, r, sg, x, y;
    logic c, z, n, v, h, w, zst;
    logic [5:0] m, nf;
    ci = int'(f[0]); c = 0; h = 0; v = 0; w = 1; zst = 0; r = 0; m = 6'h00;
    case (o)
      0, 1: begin
        cx = (o == 1) ? ci : 0;
        r  = x0 + y0 + cx;
        c  = r > 255;
        h  = ((x0 % 16) + (y0 % 16) + cx) > 15;
        sg = sx(x0) + sx(y0) + cx;
        v  = (sg > 127) || (sg < -128);
        r  = r & 255; m = 6'h3F;
      end
      2, 3, 4, 5, 6: begin
        x  = (o == 6) ? 0 : x0;
        y  = (o == 6) ? x0 : y0;
        cx = (o == 3 || o == 5) ? ci : 0;
        r  = x - y - cx;
        c  = r < 0;
        h  = ((x % 16) - (y % 16) - cx) < 0;
        sg = sx(x) - sx(y) - cx;
        v  = (sg > 127) || (sg < -128);
        r  = r & 255; m = 6'h3F;
        w  = !(o == 4 || o == 5);
        zst = (o == 3 || o == 5);
      end
      7:  begin r = x0 & y0; m = 6'h1E; end
      8:  begin r = x0 | y0; m = 6'h1E; end
      9:  begin r = x0 ^ y0; m = 6'h1E; end
      10: begin r = 255 - x0; c = 1; m = 6'h1F; end
      11: begin r = (x0 + 1) & 255; v = (x0 == 127); m = 6'h1E; end
      12: begin r = (x0 + 255) & 255; v = (x0 == 128); m = 6'h1E; end
      13: begin r = (x0 * 2) & 255; c = x0 >= 128; h = ((x0 / 8) % 2) == 1; m = 6'h3F; end
      14: begin r = x0 / 2; c = (x0 % 2) == 1; m = 6'h1F; end
      15: begin r = ((x0 * 2) & 255) + ci; c = x0 >= 128; h = ((x0 / 8) % 2) == 1; m = 6'h3F; end
      16: begin r = x0 / 2 + ci * 128; c = (x0 % 2) == 1; m = 6'h1F; end
      17: begin r = x0 / 2 + (x0 & 128); c = (x0 % 2) == 1; m = 6'h1F; end
      18: begin r = (x0 % 16) * 16 + x0 / 16; m = 6'h00; end
      default: begin r = x0; m = 6'h00; w = 0; end
    endcase
    n = r >= 128;
    if (o >= 13 && o <= 17) v = n ^ c;
    z = (r == 0);
    if (zst) z = z & f[1];
    nf = {h, n ^ v, v, n, z, c};
    return {w, m, (f & ~m) | (nf & m), 8'(r)};
  endfunction

  function automatic string rtag(input int o);
    case (o)
      0, 1:          return "R1";
      2, 6:          return "R2";
      3:             return "R4";
      4:             return "R3";
      5:             return "R4";
      7, 8, 9:       return "R5";
      10:            return "R6";
      11, 12:        return "R7";
      13, 14:        return "R8";
      15, 16:        return "R9";
      17:            return "R10";
      18:            return "R11";
      default:       return "R13";
    endcase
  endfunction

  task automatic run(input int o, input int x, input int y, input logic [5:0] f, input string tag);
    logic [20:0] exp_v, act_v;
    @(negedge clk);
    op = 5'(o); a = 8'(x); b = 8'(y); fin = f;
    #1;
    exp_v = model(o, x, y, f);
    act_v = {we, upd, fout, res};
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s op=%0d a=%02h b=%02h fin=%02h actual we=%b upd=%02h flags=%02h res=%02h expected we=%b upd=%02h flags=%02h res=%02h",
               tag, o, x, y, f, act_v[20], act_v[19:14], act_v[13:8], act_v[7:0],
               exp_v[20], exp_v[19:14], exp_v[13:8], exp_v[7:0]);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    op = 5'd0; a = 8'h00; b = 8'h00; fin = 6'h00;
    repeat (3) @(posedge clk);
    // reset state: idle inputs give a zero sum, Z set (R1)
    @(negedge clk);
    #1;
    checks++;
    if (res !== 8'h00 || fout !== 6'h3F & 6'h02 || we !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset actual res=%02h flags=%02h expected res=00 flags=02", res, fout);
    end
    rst_n = 1'b1;

    // directed corners
    run(0,  8'h7F, 8'h01, 6'h00, "R1");  // signed overflow, half carry
    run(1,  8'hFF, 8'h00, 6'h01, "R1");  // carry in wraps to zero
    run(2,  8'h00, 8'h01, 6'h00, "R2");  // borrow
    run(6,  8'h80, 8'h00, 6'h00, "R2");  // negate most negative
    run(6,  8'h00, 8'h00, 6'h3F, "R2");  // negate zero
    run(4,  8'h42, 8'h42, 6'h00, "R3");  // equal compare, no write
    run(5,  8'h10, 8'h10, 6'h00, "R4");  // chained compare, Z stays clear
    run(5,  8'h10, 8'h10, 6'h02, "R4");  // chained compare, Z stays set
    run(3,  8'h01, 8'h00, 6'h03, "R4");  // sub with carry to zero, Z kept
    run(7,  8'hF0, 8'h0F, 6'h29, "R5");  // AND to zero, C and H kept
    run(9,  8'hAA, 8'h55, 6'h08, "R5");  // XOR, V cleared
    run(10, 8'h00, 8'h00, 6'h20, "R6");  // complement keeps H
    run(11, 8'h7F, 8'h00, 6'h21, "R7");  // increment overflow, C kept
    run(12, 8'h80, 8'h00, 6'h01, "R7");  // decrement overflow
    run(11, 8'hFF, 8'h00, 6'h00, "R7");  // increment wrap, C not set
    run(13, 8'h88, 8'h00, 6'h00, "R8");
    run(14, 8'h01, 8'h00, 6'h00, "R8");
    run(15, 8'h80, 8'h00, 6'h01, "R9");
    run(16, 8'h01, 8'h00, 6'h01, "R9");
    run(17, 8'h81, 8'h00, 6'h00, "R10");
    run(18, 8'h3C, 8'h00, 6'h15, "R11");
    run(19, 8'h5A, 8'h11, 6'h2A, "R13");
    run(31, 8'hA5, 8'hFF, 6'h15, "R13");

    // seeded random sweep over all codes (also covers R12 merging)
    void'($urandom(32'd20250117));
    for (int i = 0; i < 4000; i++) begin
      int o;
      o = int'($urandom_range(31, 0));
      run(o, int'($urandom_range(255, 0)), int'($urandom_range(255, 0)),
          6'($urandom_range(63, 0)), (i % 5 == 0) ? "R12" : rtag(o));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule